// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status Word

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. It holds the accumulator itself, takes a second operand from a temporary-register input, and forms a combinational result selected by a 4-bit operation code. The result can be written back into the accumulator, and a five-flag status word can be updated, each under its own write enable on the rising clock edge.

The status word carries sign, zero, half-carry (carry or borrow across the nibble boundary), even parity and carry. The carry-in for the add-with-carry and subtract-with-borrow operations is the registered carry flag. The instruction decoder around the block drives the opcode and the two enables. Shifts, rotates, multiply, divide, decimal adjust and the register file are left to other blocks.

Top module: `alu8_core`

## Requirements
- R1: Opcodes 0 to 3 select add, add with carry-in, subtract and subtract with borrow-in. The 8-bit `result` is the low byte of accumulator plus or minus `tmp_in`, plus or minus the registered carry flag for opcodes 1 and 3. Opcodes 10 and 11 give accumulator plus one and accumulator minus one.
- R2: Opcodes 4 to 9 give accumulator AND, OR, XOR and XNOR with `tmp_in`, then the bitwise inverse of the accumulator, then zero.
- R3: For add-type operations the carry flag becomes the carry out of bit 7. For subtract-type operations it becomes 1 exactly when `tmp_in` plus the borrow-in is greater than the accumulator, taken as unsigned numbers.
- R4: The half-carry flag becomes the carry from bit 3 into bit 4 for additions and increment. For subtractions and decrement it is the borrow out of the low nibble.
- R5: The parity flag becomes 1 when the result has an even number of one bits and 0 when the count is odd.
- R6: The zero flag becomes 1 exactly when the result is 0x00. The sign flag becomes result bit 7.
- R7: Opcodes 4 to 9 clear the carry flag. The half-carry flag becomes 1 for AND (opcode 4) and 0 for opcodes 5 to 9.
- R8: Increment and decrement leave the carry flag unchanged and update the other four flags.
- R9: `status` reads {sign, zero, 0, half-carry, 0, parity, 1, carry} from bit 7 down to bit 0.
- R10: The flags change only on a rising edge with `flag_we` high. The accumulator changes only on a rising edge with `acc_we` high, and then it takes `result`.
- R11: A synchronous reset clears the accumulator and all five flags, so `status` reads 0x02.
- R12: Opcodes 12 to 15 are reserved. For these, `result` equals the accumulator and neither the accumulator nor the flags change, whatever the enables are.
- R13: Adding 0xC8 to an accumulator of 0xCC gives result 0x94, and `status` then reads 0x93 (carry 1, half-carry 1, parity 0, zero 0, sign 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| tmp_in | input | 8 | Second operand from the temporary register |
| acc_we | input | 1 | Write `result` into the accumulator at the edge |
| flag_we | input | 1 | Update the status flags at the edge |
| result | output | 8 | Combinational operation result |
| acc_q | output | 8 | Current accumulator value |
| status | output | 8 | Packed status word |

## Verification
An accumulator write and a flag write can happen in the same cycle. A carry-consuming operation then reads the old carry flag on the same edge that replaces it. The bench provokes this with back-to-back add-with-carry and subtract-with-borrow operations with both enables high, and also with long random runs in which both enables toggle freely. A behavioural model takes the carry-in from its own pre-edge flag state, and its predicted accumulator and status are compared after every edge, so an operation that sees the freshly written carry shows up as a miscompare in the following cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int W = 8;
  localparam int H = W / 2;

  typedef logic [3:0] op_t;

  localparam op_t OP_ADD  = 4'd0;
  localparam op_t OP_ADC  = 4'd1;
  localparam op_t OP_SUB  = 4'd2;
  localparam op_t OP_SBB  = 4'd3;
  localparam op_t OP_AND  = 4'd4;
  localparam op_t OP_OR   = 4'd5;
  localparam op_t OP_XOR  = 4'd6;
  localparam op_t OP_XNOR = 4'd7;
  localparam op_t OP_CPL  = 4'd8;
  localparam op_t OP_CLR  = 4'd9;
  localparam op_t OP_INC  = 4'd10;
  localparam op_t OP_DEC  = 4'd11;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic op_is_valid(op_t o);
    return o <= OP_DEC;
  endfunction

  function automatic logic op_is_logic(op_t o);
    return (o >= OP_AND) && (o <= OP_CLR);
  endfunction

  function automatic logic op_is_step(op_t o);
    return (o == OP_INC) || (o == OP_DEC);
  endfunction

  // Full-width sum; the top bit is the carry out.
  function automatic logic [W:0] wide_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  // Full-width difference; the top bit is the borrow out.
  function automatic logic [W:0] wide_sub(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} - {1'b0, y} - {{W{1'b0}}, c};
  endfunction

  function automatic logic [H:0] nib_add(logic [H-1:0] x, logic [H-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{H{1'b0}}, c};
  endfunction

  function automatic logic [H:0] nib_sub(logic [H-1:0] x, logic [H-1:0] y, logic c);
    return {1'b0, x} - {1'b0, y} - {{H{1'b0}}, c};
  endfunction

  // Status byte layout: S Z 0 AC 0 P 1 CY
  function automatic logic [7:0] pack_status(flags_t f);
    return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         hc
);
  logic [W:0] full;
  logic [H:0] half;
  logic       c_eff;

  always_comb begin
    c_eff = ((op == OP_ADC) || (op == OP_SBB)) ? cin : 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        full = wide_add(a, b, c_eff);
        half = nib_add(a[H-1:0], b[H-1:0], c_eff);
      end
      OP_SUB, OP_SBB: begin
        full = wide_sub(a, b, c_eff);
        half = nib_sub(a[H-1:0], b[H-1:0], c_eff);
      end
      OP_INC: begin
        full = wide_add(a, {W{1'b0}}, 1'b1);
        half = nib_add(a[H-1:0], {H{1'b0}}, 1'b1);
      end
      OP_DEC: begin
        full = wide_sub(a, {W{1'b0}}, 1'b1);
        half = nib_sub(a[H-1:0], {H{1'b0}}, 1'b1);
      end
      default: begin
        full = {1'b0, a};
        half = '0;
      end
    endcase
    res = full[W-1:0];
    cy  = full[W];
    hc  = half[H];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         hc
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_XNOR: res = ~(a ^ b);
      OP_CPL:  res = ~a;
      default: res = '0;
    endcase
    hc = (op == OP_AND);
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  op_t          op,
  input  logic [W-1:0] res,
  input  logic         arith_cy,
  input  logic         arith_hc,
  input  logic         logic_hc,
  input  logic         flag_we,
  output flags_t       q
);
  flags_t nxt;

  always_comb begin
    nxt.s = res[W-1];
    nxt.z = ~|res;
    nxt.p = ~^res;
    if (op_is_logic(op)) begin
      nxt.cy = 1'b0;
      nxt.ac = logic_hc;
    end else if (op_is_step(op)) begin
      nxt.cy = q.cy;
      nxt.ac = arith_hc;
    end else begin
      nxt.cy = arith_cy;
      nxt.ac = arith_hc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (flag_we && op_is_valid(op))
      q <= nxt;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] op,
  input  logic [7:0] tmp_in,
  input  logic       acc_we,
  input  logic       flag_we,
  output logic [7:0] result,
  output logic [7:0] acc_q,
  output logic [7:0] status
);
  logic [W-1:0] acc_r;
  logic [W-1:0] arith_res;
  logic [W-1:0] logic_res;
  logic         arith_cy;
  logic         arith_hc;
  logic         logic_hc;
  logic         op_ok;
  flags_t       flags;

  assign op_ok = op_is_valid(op);

  alu8_arith u_arith (
    .op  (op),
    .a   (acc_r),
    .b   (tmp_in),
    .cin (flags.cy),
    .res (arith_res),
    .cy  (arith_cy),
    .hc  (arith_hc)
  );

  alu8_logic u_logic (
    .op  (op),
    .a   (acc_r),
    .b   (tmp_in),
    .res (logic_res),
    .hc  (logic_hc)
  );

  always_comb begin
    if (!op_ok)
      result = acc_r;
    else if (op_is_logic(op))
      result = logic_res;
    else
      result = arith_res;
  end

  alu8_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .res      (result),
    .arith_cy (arith_cy),
    .arith_hc (arith_hc),
    .logic_hc (logic_hc),
    .flag_we  (flag_we),
    .q        (flags)
  );

  always_ff @(posedge clk) begin
    if (rst)
      acc_r <= '0;
    else if (acc_we && op_ok)
      acc_r <= result;
  end

  assign acc_q  = acc_r;
  assign status = pack_status(flags);
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] op,
  input logic       acc_we,
  input logic       flag_we,
  input logic       op_ok,
  input logic       arith_cy,
  input logic [7:0] result,
  input logic [7:0] acc_q,
  input logic [7:0] status
);
  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (acc_q == 8'h00) && (status == 8'h02));

  assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (status[5] == 1'b0) && (status[3] == 1'b0) && (status[1] == 1'b1));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(status));

  assert_acc_load_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_we && op_ok) |=> (acc_q == $past(result)));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op_ok) |=> (status[6] == ($past(result) == 8'h00)));

  assert_logic_clears_cy_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (op >= 4'd4) && (op <= 4'd9)) |=> (status[0] == 1'b0));

  assert_step_keeps_cy_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_we && ((op == 4'd10) || (op == 4'd11))) |=> $stable(status[0]));

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (flag_we && (op <= 4'd3)) |=> (status[0] == $past(arith_cy)));

  assert_reserved_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !op_ok |=> ($stable(acc_q) && $stable(status)));
endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .op       (op),
  .acc_we   (acc_we),
  .flag_we  (flag_we),
  .op_ok    (op_ok),
  .arith_cy (arith_cy),
  .result   (result),
  .acc_q    (acc_q),
  .status   (status)
);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = 4'd0;
  logic [7:0] tmp_in = 8'h00;
  logic       acc_we = 1'b0;
  logic       flag_we = 1'b0;
  logic [7:0] result;
  logic [7:0] acc_q;
  logic [7:0] status;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  int m_acc = 0;
  int m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

  always #5 clk = ~clk;

  alu8_core uut (
    .clk(clk), .rst(rst), .op(op), .tmp_in(tmp_in),
    .acc_we(acc_we), .flag_we(flag_we),
    .result(result), .acc_q(acc_q), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (op %0d tmp %0h)", tag, act, exp, op, tmp_in);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic int model_status();
    return (m_s << 7) | (m_z << 6) | (m_ac << 4) | (m_p << 2) | 2 | m_cy;
  endfunction

  // One clock: drive at negedge, check result, update model at edge, check registers.
  task automatic step(input int o, input int b, input bit awe, input bit fwe, input bit r);
    int a, r_val, cy, ac, sum;
    string rtag, ctag, htag;
    @(negedge clk);
    op = o[3:0]; tmp_in = b[7:0]; acc_we = awe; flag_we = fwe; rst = r;
    a = m_acc; cy = m_cy; ac = 0; r_val = a;
    rtag = "R1"; ctag = "R3"; htag = "R4";
    case (o)
      0, 1: begin
        sum = a + b + ((o == 1) ? m_cy : 0);
        r_val = sum % 256; cy = (sum > 255);
        ac = ((a % 16) + (b % 16) + ((o == 1) ? m_cy : 0)) > 15;
      end
      2, 3: begin
        sum = b + ((o == 3) ? m_cy : 0);
        r_val = (a - sum + 512) % 256; cy = (sum > a);
        ac = ((b % 16) + ((o == 3) ? m_cy : 0)) > (a % 16);
      end
      4: begin r_val = a & b; cy = 0; ac = 1; end
      5: begin r_val = a | b; cy = 0; ac = 0; end
      6: begin r_val = a ^ b; cy = 0; ac = 0; end
      7: begin r_val = 255 - (a ^ b); cy = 0; ac = 0; end
      8: begin r_val = 255 - a; cy = 0; ac = 0; end
      9: begin r_val = 0; cy = 0; ac = 0; end
      10: begin r_val = (a + 1) % 256; ac = ((a % 16) == 15); end
      11: begin r_val = (a + 255) % 256; ac = ((a % 16) == 0); end
      default: r_val = a;
    endcase
    if (o >= 4 && o <= 9) begin rtag = "R2"; ctag = "R7"; htag = "R7"; end
    if (o == 10 || o == 11) ctag = "R8";
    if (o >= 12) rtag = "R12";
    #2;
    chk(rtag, result, r_val);
    @(posedge clk);
    if (r) begin
      m_acc = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
    end else if (o <= 11) begin
      if (awe) m_acc = r_val;
      if (fwe) begin
        m_cy = cy; m_ac = ac;
        m_s = (r_val >> 7) & 1; m_z = (r_val == 0);
        m_p = (ones(r_val) % 2 == 0);
      end
    end
    #2;
    if (r) begin
      chk("R11 acc", acc_q, m_acc);
      chk("R11 status", status, model_status());
    end else if (o >= 12) begin
      chk("R12 acc", acc_q, m_acc);
      chk("R12 status", status, model_status());
    end else begin
      chk(awe ? "R10 acc load" : "R10 acc hold", acc_q, m_acc);
      if (!fwe) chk("R10 flags hold", status, model_status());
      else begin
        chk({ctag, " carry"}, status[0], m_cy);
        chk({htag, " half-carry"}, status[4], m_ac);
        chk("R5 parity", status[2], m_p);
        chk("R6 zero", status[6], m_z);
        chk("R6 sign", status[7], m_s);
        chk("R9 fixed bits", {status[5], status[3], status[1]}, 3'b001);
      end
    end
  endtask

  initial begin
    // reset state
    step(0, 0, 1'b1, 1'b1, 1'b1);
    step(0, 0, 1'b0, 1'b0, 1'b1);
    // clear then load 0xCC
    step(9, 8'h55, 1'b1, 1'b1, 1'b0);
    chk("R6 clear status", status, 8'h46);
    step(0, 8'hCC, 1'b1, 1'b0, 1'b0);
    // worked example, R13
    step(0, 8'hC8, 1'b1, 1'b1, 1'b0);
    chk("R13 acc", acc_q, 8'h94);
    chk("R13 status", status, 8'h93);
    // carry chain with both enables: ADC/SBB read the pre-edge carry
    step(1, 8'h7F, 1'b1, 1'b1, 1'b0);
    step(1, 8'hFF, 1'b1, 1'b1, 1'b0);
    step(3, 8'hFF, 1'b1, 1'b1, 1'b0);
    step(3, 8'h00, 1'b1, 1'b1, 1'b0);
    step(2, 8'h01, 1'b1, 1'b1, 1'b0);
    // logic half-carry and carry clear
    step(4, 8'hF0, 1'b0, 1'b1, 1'b0);
    step(5, 8'h0F, 1'b0, 1'b1, 1'b0);
    step(7, 8'h3C, 1'b1, 1'b1, 1'b0);
    step(8, 8'h00, 1'b1, 1'b1, 1'b0);
    // increment across 0xFF keeps carry; decrement from 0x00
    step(9, 0, 1'b1, 1'b0, 1'b0);
    step(11, 0, 1'b1, 1'b1, 1'b0);
    step(0, 8'h01, 1'b0, 1'b1, 1'b0);
    step(10, 0, 1'b1, 1'b1, 1'b0);
    step(10, 0, 1'b1, 1'b1, 1'b0);
    // reserved opcodes with enables high
    for (int k = 12; k < 16; k++) step(k, 8'hA5, 1'b1, 1'b1, 1'b0);
    // random run
    for (int i = 0; i < 4000; i++)
      step($urandom_range(0, 15), $urandom_range(0, 255),
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 63) == 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule